// File: doc/BRIEF.md
# Registered Packed-Decimal Adder/Subtractor

This block is the decimal arithmetic unit of a small 8-bit processor datapath. It takes two packed-BCD operands of two decimal digits each, plus a carry-in, and produces a packed-BCD result, a decimal carry, and a two's-complement style overflow flag. A mode input selects addition or subtraction.

The block never inverts its second operand. For subtraction, an operand multiplexer outside the block supplies the bitwise complement of the subtrahend. The block then applies the decimal correction that belongs to the selected mode. The carry-in enters at the least significant digit. In subtract mode a carry-in of 1 means "no borrow", and a result carry of 1 means that no borrow came out.

The result is registered, so it appears one cycle after the enable is sampled high. In any cycle after the enable was sampled low, all outputs are zero. This lets the unit share a wired-OR result bus with other functional units. The digit count is a parameter with a default of two.

Top module: `bcd_addsub_reg`

## Requirements
- R1: In the cycle after the enable is sampled low, `result`, `ovf` and `valid` are all zero, whatever the other inputs are.
- R2: `valid` is high in exactly the cycles that follow a clock edge where the enable was sampled high. The result computed from the inputs at that edge appears in the same cycle.
- R3: Add mode (`sub`=0) gives the following result. Bits 7:0 hold the packed digits (tens in bits 7:4, units in bits 3:0) of (A + B + ci) mod 100. Bit 8 is 1 when that sum is 100 or more.
- R4: Subtract mode (`sub`=1) treats `b` as the ones' complement of the subtrahend. Bits 7:0 hold the digits of (A − subtrahend − (1 − ci)) mod 100. Bit 8 is 1 when the difference is not negative (no borrow).
- R5: The carry-in acts at the units digit. In add mode, ci=1 adds one. In subtract mode, ci=0 subtracts one extra, and that borrow can ripple through both digits.
- R6: `ovf` equals the carry into bit 7 XOR the carry out of bit 7 of the binary sum of the upper nibbles of `a` and `b`. Into that sum goes the units-digit carry: in add mode the carry is set when the units binary sum exceeds 9; in subtract mode it is the binary nibble carry.
- R7: When both A and the subtrahend are valid BCD, every result digit is in the range 0 to 9.
- R8: A synchronous reset clears `result`, `ovf` and `valid` at the next clock edge, even while the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start an operation with the present operands |
| sub | input | 1 | 0 selects addition, 1 selects subtraction |
| a | input | 8 | Packed-BCD first operand |
| b | input | 8 | Packed-BCD second operand (complemented subtrahend in subtract mode) |
| ci | input | 1 | Carry-in; in subtract mode 1 means no borrow |
| result | output | 9 | {decimal carry, packed-BCD result} |
| ovf | output | 1 | Overflow flag |
| valid | output | 1 | Result present this cycle |

## Verification
Two things can land on the upper digit in the same cycle: the correction carry from the units digit, and a carry-in that ripples all the way through. The bench provokes both together with 99 + 00 + 1 and 99 + 99 + 1 in add mode, and with 00 − 00 and a borrow-in in subtract mode, where both digits must wrap to 9. The other pairing is a result and its removal on consecutive cycles. The enable is dropped right after a busy cycle, and reset is raised while the enable is high, and the zero outputs are checked on the very next sample. Every case is judged against a decimal model written as arithmetic on digit values.

// File: rtl/bcd_addsub_reg.sv
module bcd_addsub_reg #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W:0]   result,
  output logic         ovf,
  output logic         valid
);

  logic [DIGITS:0] dcarry;
  logic [4:0]      raw [DIGITS];
  logic [W-1:0]    digits;
  logic [3:0]      top_low;
  logic            ov_c;

  assign dcarry[0] = ci;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic fix;
    assign raw[g] = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, dcarry[g]};
    assign fix = sub ? ~raw[g][4] : (raw[g] > 5'd9);
    assign dcarry[g+1] = sub ? raw[g][4] : fix;
    assign digits[4*g +: 4] = !fix ? raw[g][3:0]
                            : sub  ? raw[g][3:0] - 4'd6
                                   : raw[g][3:0] + 4'd6;
  end

  assign top_low = {1'b0, a[W-2 -: 3]} + {1'b0, b[W-2 -: 3]} + {3'd0, dcarry[DIGITS-1]};
  assign ov_c    = top_low[3] ^ raw[DIGITS-1][4];

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ovf    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid  <= en;
      result <= en ? {dcarry[DIGITS], digits} : '0;
      ovf    <= en & ov_c;
    end
  end

  function automatic logic all_bcd(input logic [W-1:0] v);
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  logic in_bcd;
  assign in_bcd = all_bcd(a) && all_bcd(sub ? ~b : b);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (result == '0) && !ovf && !valid);

  p_valid_follows_en_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> valid);

  p_idle_bus_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (result == '0) && !ovf);

  p_digits_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (en && in_bcd) |=> all_bcd(result[W-1:0]));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (result == '0) && !ovf && !valid);

endmodule

// File: tb/tb_bcd_addsub_reg.sv
module tb_bcd_addsub_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, en, sub, ci;
  logic [7:0] a, b;
  logic [8:0] result;
  logic ovf, valid;
  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_addsub_reg dut (
    .clk(clk), .rst(rst), .en(en), .sub(sub), .a(a), .b(b), .ci(ci),
    .result(result), .ovf(ovf), .valid(valid)
  );

  function automatic int dec(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] rnd_bcd();
    return bcd(int'($urandom % 100));
  endfunction

  function automatic logic [8:0] exp_result(input logic s, input logic [7:0] x,
                                            input logic [7:0] bin, input logic c);
    int v;
    if (!s) begin
      v = dec(x) + dec(bin) + int'(c);
      return {v >= 100, bcd(v % 100)};
    end
    v = dec(x) - dec(~bin) - (1 - int'(c));
    if (v < 0) return {1'b0, bcd(v + 100)};
    return {1'b1, bcd(v)};
  endfunction

  function automatic logic exp_ovf(input logic s, input logic [7:0] x,
                                   input logic [7:0] bin, input logic c);
    int lo, c1, cin7, cout7;
    lo = int'(x[3:0]) + int'(bin[3:0]) + int'(c);
    c1 = s ? int'(lo > 15) : int'(lo > 9);
    cin7  = int'((int'(x[6:4]) + int'(bin[6:4]) + c1) > 7);
    cout7 = int'((int'(x[7:4]) + int'(bin[7:4]) + c1) > 15);
    return logic'(cin7 ^ cout7);
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic op(input string tag, input logic e, input logic s,
                    input logic [7:0] x, input logic [7:0] y, input logic c);
    en = e; sub = s; a = x; b = y; ci = c;
    @(negedge clk);
    if (e) begin
      check({tag, " R2 valid"}, int'(valid), 1);
      check({tag, " result"}, int'(result), int'(exp_result(s, x, y, c)));
      check({tag, " R6 ovf"}, int'(ovf), int'(exp_ovf(s, x, y, c)));
    end else begin
      check({tag, " R1 idle"}, int'({result, ovf, valid}), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst = 1'b1; en = 1'b1; sub = 1'b0; a = 8'h99; b = 8'h99; ci = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 reset state", int'({result, ovf, valid}), 0);
    rst = 1'b0;

    op("R3 45+37", 1, 0, 8'h45, 8'h37, 0);
    op("R3 99+01", 1, 0, 8'h99, 8'h01, 0);
    op("R5 99+00+ci", 1, 0, 8'h99, 8'h00, 1);
    op("R5 99+99+ci", 1, 0, 8'h99, 8'h99, 1);
    op("R5 00+00+ci", 1, 0, 8'h00, 8'h00, 1);
    op("R1 after busy", 0, 1, 8'h77, 8'h12, 1);
    op("R4 50-25", 1, 1, 8'h50, ~8'h25, 1);
    op("R4 00-01", 1, 1, 8'h00, ~8'h01, 1);
    op("R5 00-00 borrow", 1, 1, 8'h00, ~8'h00, 0);
    op("R4 81-81", 1, 1, 8'h81, ~8'h81, 1);
    op("R6 79+01", 1, 0, 8'h79, 8'h01, 0);
    op("R6 80-01", 1, 1, 8'h80, ~8'h01, 1);
    op("R1 idle again", 0, 0, 8'h99, 8'h99, 1);

    en = 1'b1; sub = 1'b0; a = 8'h12; b = 8'h34; ci = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R8 reset with enable", int'({result, ovf, valid}), 0);
    rst = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic s, c, e;
      logic [7:0] x, y;
      s = 1'($urandom); c = 1'($urandom); e = ($urandom % 8) != 0;
      x = rnd_bcd(); y = rnd_bcd();
      if (s) y = ~y;
      op(s ? "R4 R7 random sub" : "R3 R7 random add", e, s, x, y, c);
      if (e) begin
        total++;
        if (result[3:0] > 4'd9 || result[7:4] > 4'd9) begin
          fails++;
          $display("FAIL R7 digit range: actual %0h expected digits <= 9", result);
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule